// File: doc/BRIEF.md
# Manual-Step Fuse Read Controller

This block lets software walk a read-only one-time-programmable fuse macro through a read one pin at a time. A small 32-bit register bus exposes two words. The control word holds the macro's select, program-enable, load and strobe pins and a 10-bit byte address. The data word returns the sensed byte and two sticky error flags. Behind the registers sits a behavioural fuse array of 1024 bytes. A preload port fills the array, and the bus can never change its contents.

A read state machine follows the pin levels held in the control word. A byte is sensed only when a strobe rising edge finds the macro selected and in read mode. Any strobe edge seen while program enable is active is refused and flagged. A setup timer counts clock cycles from the last change of the address field. A read strobe that comes too early still senses, and it also latches a timing-violation flag.

The machine states are:
- STANDBY: select inactive, strobe low.
- PARK: select inactive, strobe high.
- SELECT: selected, strobe low, not in read mode.
- ARMED: selected, strobe low, load high, program enable inactive.
- SENSE: strobe high after a valid read edge.
- REFUSE: strobe high after a program-attempt edge.
- HOLD: strobe high with no effect.

The transitions are:
- Each strobe-low state goes to its base state while strobe stays low. The base state is STANDBY, ARMED or SELECT, picked from the select, load and program-enable levels.
- When strobe goes high in a strobe-low state, the next state is chosen in this order: PARK if select is inactive, else REFUSE if program enable is active, else SENSE if load is high, else HOLD.
- Each strobe-high state goes to the base state when strobe drops.
- While strobe stays high, a strobe-high state moves to PARK if select goes inactive. PARK moves to HOLD if select becomes active. SENSE, REFUSE and HOLD otherwise stay where they are.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000_0009, which is standby: select-bar (bit 0) set, program-enable-bar (bit 3) set, load and strobe clear, address 0. The data word reads 0.
- R2: The control word sits at byte offset 0x0 and the data word at byte offset 0x4. In the control word, bits 15:6 are the address, bit 3 is program-enable-bar, bit 2 is load, bit 1 is strobe and bit 0 is select-bar; all other control bits read 0. Writes to the data word have no effect. Any other offset reads 0.
- R3: A strobe rising edge with select-bar 0, load 1 and program-enable-bar 1 loads the array byte at the current address into data bits 7:0. The new byte is visible from the cycle after the clock edge that wrote the strobe.
- R4: The data byte is unchanged in these cases: strobe held high, strobe falling, address changes while strobe is high, and strobe rising with select-bar 1 or with load 0.
- R5: A strobe rising edge with select-bar 0 and program-enable-bar 0 sets data bit 31 (program-attempt). It leaves both the array and the data byte unchanged.
- R6: A read edge whose strobe write comes fewer than SETUP_CYC cycles after the write that changed the address sets data bit 30 (setup violation). The byte is still captured. Rewriting the same address does not restart the count.
- R7: Data bits 31 and 30 stay set until reset.
- R8: A pulse on the preload strobe writes the preload byte into the array at the preload address. A later read of that address returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| pre_we | input | 1 | Array preload write enable |
| pre_addr | input | 10 | Array preload byte address |
| pre_data | input | 8 | Array preload byte |

## Verification
Assertions check four things on every cycle: the standby reset value, that a capture only happens when the pins are in read configuration, that the data byte never moves without a capture, and that both error flags are set only by their cause and stay sticky. Only the bench scenarios can show that the right array byte lands for every one of the 1024 addresses. They also show that a program attempt leaves the array intact, that the setup window is counted from an address change and not from a plain rewrite, and that preloaded edge addresses read back.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
    localparam int FUSE_AW     = 10;
    localparam int FUSE_DEPTH  = 1 << FUSE_AW;
    localparam int WORD_CTRL   = 0;
    localparam int WORD_DATA   = 1;
    localparam int B_CS_N      = 0;
    localparam int B_STROBE    = 1;
    localparam int B_LOAD      = 2;
    localparam int B_PGEN_N    = 3;
    localparam int B_ADDR_LSB  = 6;
    localparam int B_VIOL      = 30;
    localparam int B_PROG_ERR  = 31;

    typedef struct packed {
        logic [FUSE_AW-1:0] addr;
        logic               pgen_n;
        logic               load;
        logic               strobe;
        logic               cs_n;
    } fuse_ctrl_t;

    localparam fuse_ctrl_t CTRL_RST = '{addr: '0, pgen_n: 1'b1, load: 1'b0,
                                        strobe: 1'b0, cs_n: 1'b1};

    typedef enum logic [2:0] {
        S_STANDBY, S_PARK, S_SELECT, S_ARMED, S_SENSE, S_REFUSE, S_HOLD
    } fsm_state_e;
endpackage

// File: rtl/fuse_bus_regs.sv
module fuse_bus_regs
    import fuse_rd_pkg::*;
#(
    parameter int BUS_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        sense_byte,
    input  logic              prog_err,
    input  logic              setup_viol,
    output fuse_ctrl_t        ctrl_o,
    output logic              addr_chg_o
);
    localparam int WAW = BUS_AW - 2;

    logic [WAW-1:0] word;
    logic           wr_ctrl;
    fuse_ctrl_t     ctrl_q;
    fuse_ctrl_t     ctrl_wr;
    logic           unused_bits;

    assign word    = bus_addr[BUS_AW-1:2];
    assign wr_ctrl = bus_we && (word == WAW'(WORD_CTRL));
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16], bus_wdata[5:4]};

    always_comb begin
        ctrl_wr.addr   = bus_wdata[B_ADDR_LSB +: FUSE_AW];
        ctrl_wr.pgen_n = bus_wdata[B_PGEN_N];
        ctrl_wr.load   = bus_wdata[B_LOAD];
        ctrl_wr.strobe = bus_wdata[B_STROBE];
        ctrl_wr.cs_n   = bus_wdata[B_CS_N];
    end

    assign addr_chg_o = wr_ctrl && (ctrl_wr.addr != ctrl_q.addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= CTRL_RST;
        else if (wr_ctrl) ctrl_q <= ctrl_wr;
    end

    assign ctrl_o = ctrl_q;

    always_comb begin
        bus_rdata = '0;
        if (word == WAW'(WORD_CTRL)) begin
            bus_rdata[B_ADDR_LSB +: FUSE_AW] = ctrl_q.addr;
            bus_rdata[B_PGEN_N]              = ctrl_q.pgen_n;
            bus_rdata[B_LOAD]                = ctrl_q.load;
            bus_rdata[B_STROBE]              = ctrl_q.strobe;
            bus_rdata[B_CS_N]                = ctrl_q.cs_n;
        end else if (word == WAW'(WORD_DATA)) begin
            bus_rdata[7:0]        = sense_byte;
            bus_rdata[B_VIOL]     = setup_viol;
            bus_rdata[B_PROG_ERR] = prog_err;
        end
    end
endmodule

// File: rtl/fuse_setup_timer.sv
module fuse_setup_timer #(
    parameter int SETUP_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic setup_met
);
    localparam int CW = $clog2(SETUP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETUP_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= LIMIT;
        else if (restart)        cnt_q <= '0;
        else if (cnt_q < LIMIT)  cnt_q <= cnt_q + 1'b1;
    end

    assign setup_met = (cnt_q >= LIMIT);
endmodule

// File: rtl/fuse_read_fsm.sv
module fuse_read_fsm
    import fuse_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fuse_ctrl_t ctrl,
    input  logic       setup_met,
    output logic       cap_o,
    output logic       refuse_o,
    output logic       prog_err_o,
    output logic       setup_viol_o
);
    fsm_state_e state_q, state_d, base;
    logic prog_err_q, viol_q;

    always_comb begin
        if (ctrl.cs_n)                    base = S_STANDBY;
        else if (ctrl.load && ctrl.pgen_n) base = S_ARMED;
        else                              base = S_SELECT;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_STANDBY, S_SELECT, S_ARMED: begin
                if (!ctrl.strobe)     state_d = base;
                else if (ctrl.cs_n)   state_d = S_PARK;
                else if (!ctrl.pgen_n) state_d = S_REFUSE;
                else if (ctrl.load)   state_d = S_SENSE;
                else                  state_d = S_HOLD;
            end
            S_PARK: begin
                if (!ctrl.strobe)     state_d = base;
                else if (ctrl.cs_n)   state_d = S_PARK;
                else                  state_d = S_HOLD;
            end
            S_SENSE, S_REFUSE, S_HOLD: begin
                if (!ctrl.strobe)     state_d = base;
                else if (ctrl.cs_n)   state_d = S_PARK;
                else                  state_d = state_q;
            end
            default:                  state_d = S_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_STANDBY;
        else        state_q <= state_d;
    end

    always_comb begin
        cap_o    = (state_d == S_SENSE)  && (state_q != S_SENSE);
        refuse_o = (state_d == S_REFUSE) && (state_q != S_REFUSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_err_q <= 1'b0;
            viol_q     <= 1'b0;
        end else begin
            if (refuse_o)              prog_err_q <= 1'b1;
            if (cap_o && !setup_met)   viol_q     <= 1'b1;
        end
    end

    assign prog_err_o   = prog_err_q;
    assign setup_viol_o = viol_q;
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model
    import fuse_rd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pre_we,
    input  logic [FUSE_AW-1:0] pre_addr,
    input  logic [7:0]         pre_data,
    input  logic               cap,
    input  logic [FUSE_AW-1:0] rd_addr,
    output logic [7:0]         sense_o
);
    logic [7:0] cells [FUSE_DEPTH];
    logic [7:0] sense_q;

    always_ff @(posedge clk) begin
        if (pre_we) cells[pre_addr] <= pre_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sense_q <= '0;
        else if (cap) sense_q <= cells[rd_addr];
    end

    assign sense_o = sense_q;
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int BUS_AW    = 4,
    parameter int SETUP_CYC = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               pre_we,
    input  logic [FUSE_AW-1:0] pre_addr,
    input  logic [7:0]         pre_data
);
    fuse_ctrl_t ctrl_q;
    logic       addr_chg, setup_met, cap_pulse, refuse_pulse;
    logic       prog_err_q, setup_viol_q;
    logic [7:0] sense_byte;

    fuse_bus_regs #(.BUS_AW(BUS_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sense_byte(sense_byte),
        .prog_err(prog_err_q), .setup_viol(setup_viol_q),
        .ctrl_o(ctrl_q), .addr_chg_o(addr_chg)
    );

    fuse_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(addr_chg), .setup_met(setup_met)
    );

    fuse_read_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .setup_met(setup_met),
        .cap_o(cap_pulse), .refuse_o(refuse_pulse),
        .prog_err_o(prog_err_q), .setup_viol_o(setup_viol_q)
    );

    fuse_array_model u_array (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .cap(cap_pulse), .rd_addr(ctrl_q.addr),
        .sense_o(sense_byte)
    );
endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
module fuse_rd_ctrl_chk
    import fuse_rd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input fuse_ctrl_t ctrl,
    input logic       cap,
    input logic       refuse,
    input logic [7:0] sense,
    input logic       prog_err,
    input logic       viol
);
    p_reset_standby_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl == CTRL_RST));

    p_cap_in_read_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (!ctrl.cs_n && ctrl.load && ctrl.pgen_n && ctrl.strobe));

    p_sense_moves_on_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sense) |-> $past(cap));

    p_refuse_no_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap && refuse));

    p_prog_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_err) |-> $past(refuse));

    p_viol_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol) |-> $past(cap));

    p_prog_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |=> prog_err);

    p_viol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);
endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .cap(cap_pulse),
    .refuse(refuse_pulse), .sense(sense_byte), .prog_err(prog_err_q),
    .viol(setup_viol_q)
);

// File: tb/tb_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module tb_fuse_rd_ctrl;
    localparam int BUS_AW = 4;
    localparam int SETUP  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pre_we = 1'b0;
    logic [9:0]  pre_addr = '0;
    logic [7:0]  pre_data = '0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [7:0] img [1024];

    always #2.5 clk = ~clk;

    fuse_rd_ctrl #(.BUS_AW(BUS_AW), .SETUP_CYC(SETUP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pre_we(pre_we),
        .pre_addr(pre_addr), .pre_data(pre_data)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37) + ((i >> 3) * 5) + 11);
    endfunction

    function automatic logic [31:0] ctl(int a, bit pg_n, bit ld, bit st, bit cs_n);
        return (32'(a & 10'h3FF) << 6) | (32'(pg_n) << 3) | (32'(ld) << 2)
             | (32'(st) << 1) | 32'(cs_n);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic preload(int a, logic [7:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = 10'(a); pre_data = v;
        @(negedge clk);
        pre_we = 1'b0;
        img[a] = v;
    endtask

    // Correctly spaced read; returns the data word
    task automatic read_byte(int a, output logic [31:0] d);
        wr(4'h0, ctl(a, 1, 1, 0, 0));
        repeat (SETUP) @(negedge clk);
        wr(4'h0, ctl(a, 1, 1, 1, 0));
        @(negedge clk);
        rd(4'h4, d);
        wr(4'h0, ctl(a, 1, 1, 0, 0));
    endtask

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset values
        rd(4'h0, v); chk("R1 ctrl reset", v, 32'h0000_0009);
        rd(4'h4, v); chk("R1 data reset", v, 32'h0);

        // R2 map, read-only data word, unused bits
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); chk("R2 data write ignored", v, 32'h0);
        wr(4'h0, 32'hFFFF_FFF9);
        rd(4'h0, v); chk("R2 ctrl field mask", v, 32'h0000_FFC9);
        rd(4'h8, v); chk("R2 unused offset", v, 32'h0);
        wr(4'h0, 32'h0000_0009);

        // R8 preload whole array
        for (int i = 0; i < 1024; i++) preload(i, pat(i));

        // R3 full sweep, no setup violation expected
        for (int i = 0; i < 1024; i++) begin
            read_byte(i, v);
            chk($sformatf("R3 byte %0d", i), v, {24'h0, img[i]});
        end

        // R4 no capture: load low, select inactive, strobe high with address change
        wr(4'h0, ctl(5, 1, 0, 0, 0));
        repeat (SETUP) @(negedge clk);
        wr(4'h0, ctl(5, 1, 0, 1, 0)); @(negedge clk);
        rd(4'h4, v); chk("R4 load low no capture", v, {24'h0, img[1023]});
        wr(4'h0, ctl(5, 1, 1, 0, 1));
        repeat (SETUP) @(negedge clk);
        wr(4'h0, ctl(5, 1, 1, 1, 1)); @(negedge clk);
        rd(4'h4, v); chk("R4 deselected no capture", v, {24'h0, img[1023]});
        wr(4'h0, ctl(5, 1, 1, 0, 0));
        wr(4'h0, ctl(5, 1, 1, 1, 0)); @(negedge clk);
        rd(4'h4, v); chk("R4 capture before hold test", v[7:0], 32'(img[5]));
        wr(4'h0, ctl(6, 1, 1, 1, 0)); @(negedge clk);
        rd(4'h4, v); chk("R4 addr change strobe high", v[7:0], 32'(img[5]));
        wr(4'h0, ctl(6, 1, 1, 0, 0)); @(negedge clk);
        rd(4'h4, v); chk("R4 strobe fall no capture", v[7:0], 32'(img[5]));

        // R6 same-address rewrite does not restart the window
        do_reset();
        wr(4'h0, ctl(7, 1, 1, 0, 0));
        repeat (SETUP) @(negedge clk);
        wr(4'h0, ctl(7, 1, 1, 0, 0));
        wr(4'h0, ctl(7, 1, 1, 1, 0)); @(negedge clk);
        rd(4'h4, v); chk("R6 rewrite keeps window", v, {24'h0, img[7]});
        wr(4'h0, ctl(7, 1, 1, 0, 0));
        // R6 early strobe: flag set, byte still captured
        wr(4'h0, ctl(300, 1, 1, 0, 0));
        wr(4'h0, ctl(300, 1, 1, 1, 0)); @(negedge clk);
        rd(4'h4, v); chk("R6 early strobe", v, {2'b01, 22'h0, img[300]});
        wr(4'h0, ctl(300, 1, 1, 0, 0));
        // R7 violation flag sticky over a clean read
        read_byte(12, v);
        chk("R7 viol sticky", v, {2'b01, 22'h0, img[12]});

        // R5 program attempt
        do_reset();
        wr(4'h0, ctl(9, 0, 1, 0, 0));
        repeat (SETUP) @(negedge clk);
        wr(4'h0, ctl(9, 0, 1, 1, 0)); @(negedge clk);
        rd(4'h4, v); chk("R5 prog attempt flagged", v, 32'h8000_0000);
        wr(4'h0, ctl(9, 0, 1, 0, 0));
        read_byte(9, v);
        chk("R5 array intact, R7 prog sticky", v, {2'b10, 22'h0, img[9]});

        // R8 edge addresses rewritten by preload
        preload(1023, 8'h5A);
        preload(0, 8'hA5);
        read_byte(1023, v); chk("R8 top address", v[7:0], 32'h5A);
        read_byte(0, v);    chk("R8 bottom address", v[7:0], 32'hA5);

        // R7 reset clears flags
        do_reset();
        rd(4'h4, v); chk("R7 flags cleared by reset", v, 32'h0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule